// File: doc/BRIEF.md
# NAND Page Program and Erase Engine

This block holds a small on-chip model of a NAND array and carries out the three array operations that a command decoder in front of it asks for. Each page has a main area and a spare area one thirty-second of its size. Pages are grouped into aligned erase blocks. The decoder raises `op_start` for one cycle with an operation kind, a page index and a column. Data bytes for a program arrive on a byte-wide input while a program setup is open. Read data leaves through a byte-wide stream that the consumer pops one byte at a time.

Programming follows NAND cell rules. The captured bytes are ANDed into the stored page, so a bit can go from 1 to 0 but never back. Only an erase restores a block to 0xFF, spare bytes included. The active-low `wp_n` input blocks both commits and erases. While a program, an erase or the power-on sweep is running, `ready` is low for a fixed number of cycles and every new operation is ignored.

Top module: `nand_pe_engine`

## Requirements
- R1: After reset, `ready` stays low for exactly NUM_PAGES cycles while every page is swept to 0xFF. A full read of any page then returns 66 bytes of 0xFF.
- R2: A read accepted at one clock edge (op_kind 0) drops `dout_valid` after that edge. From the following edge on, the stream offers bytes from the given column upward. Each byte stays on `dout` until `rd_pop` takes it.
- R3: A read ends after the last spare byte (column 65). With `spare_off` high it ends after the last main byte (column 63). A start column at or past that end yields no bytes.
- R4: A commit (op_kind 2) stores the bitwise AND of the buffered bytes and the old page contents, so a bit that is already 0 stays 0.
- R5: A program setup (op_kind 1) fills the input buffer with 0xFF and fixes the start column. Bytes buffered by an earlier setup therefore have no effect on the next commit.
- R6: Data bytes are placed at consecutive columns from the setup column. At most page-plus-spare bytes are counted. Bytes that would land past column 65 are dropped and never wrap to lower columns.
- R7: With `wp_n` low when a commit or erase is accepted, the array is left unchanged.
- R8: An erase (op_kind 3) aligns the page index down to a multiple of 16. It sets every byte of those 16 pages, spare included, to 0xFF and leaves all other pages alone.
- R9: A read, commit or erase whose page index is NUM_PAGES or higher leaves every page unchanged and streams no bytes. It never aliases onto a lower page.
- R10: An accepted commit or erase drives `ready` low for exactly BUSY_CYC cycles. Operations offered while `ready` is low are ignored.
- R11: An accepted read or setup leaves `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle request from the command decoder |
| op_kind | input | 2 | 0 read, 1 program setup, 2 program commit, 3 block erase |
| op_row | input | ROW_W | Page index (one bit wider than needed, so out-of-range values can occur) |
| op_col | input | COL_W | Start column for read or program |
| din_valid | input | 1 | A program data byte is present |
| din | input | 8 | Program data byte |
| wp_n | input | 1 | Write-protect, active low |
| spare_off | input | 1 | Read stops at the end of the main area |
| rd_pop | input | 1 | Consumer takes the current stream byte |
| ready | output | 1 | Engine idle and accepting operations |
| dout_valid | output | 1 | A stream byte is present on `dout` |
| dout | output | 8 | Current stream byte |

## Verification
A read accepted at edge k registers the page at k and loads the stream at k+1, so `dout_valid` is first due two edges after the request. A commit writes the page at the edge after it is accepted. An erase writes one page per edge for 16 edges. Both hold `ready` low for BUSY_CYC cycles, and the array change becomes visible to the first read accepted after `ready` returns. The bench runs a behavioural model with the same edge counts and compares `ready`, `dout_valid` and `dout` on every falling edge, half a period away from the edges where they change. Its directed checks collect whole streams and count busy cycles from the falling edge after the accepting edge.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_SETUP  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_ERASE  = 2'd3
  } op_e;
endpackage

// File: rtl/nand_pe_array.sv
// Page-wide storage: one synchronous read port, one write port.
module nand_pe_array #(
  parameter int WIDTH = 528,
  parameter int DEPTH = 48,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/nand_pe_inbuf.sv
// Program data buffer, indexed by column; bytes not written stay 0xFF.
module nand_pe_inbuf #(
  parameter int ROW_BYTES = 66,
  parameter int COL_W     = 7,
  localparam int ROW_BITS = ROW_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic [COL_W-1:0]    start_col,
  input  logic                wr,
  input  logic [7:0]          wdat,
  output logic [ROW_BITS-1:0] bytes_q
);
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W:0]   pos;

  assign pos = {1'b0, base_q} + {1'b0, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_q <= '1;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (clear) begin
      bytes_q <= '1;
      base_q  <= start_col;
      cnt_q   <= '0;
    end else if (wr && (cnt_q < COL_W'(ROW_BYTES))) begin
      cnt_q <= cnt_q + 1'b1;
      if (pos < (COL_W+1)'(ROW_BYTES)) bytes_q[{pos, 3'b000} +: 8] <= wdat;
    end
  end
endmodule

// File: rtl/nand_pe_sweep.sv
// Writes 0xFF pages one per cycle: whole array after reset, one block on erase.
module nand_pe_sweep #(
  parameter int NUM_PAGES = 48,
  parameter int BLK_PAGES = 16,
  localparam int PG_W = $clog2(NUM_PAGES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PG_W-1:0] base,
  output logic            act,
  output logic [PG_W-1:0] page
);
  logic [PG_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b1;
      page   <= '0;
      left_q <= PG_W'(NUM_PAGES - 1);
    end else if (start) begin
      act    <= 1'b1;
      page   <= base;
      left_q <= PG_W'(BLK_PAGES - 1);
    end else if (act) begin
      page <= page + 1'b1;
      if (left_q == '0) act <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/nand_pe_rdstream.sv
// Read stream: captures a registered page and hands it out byte by byte.
module nand_pe_rdstream #(
  parameter int PAGE_BYTES = 64,
  parameter int ROW_BYTES  = 66,
  parameter int COL_W      = 7,
  localparam int ROW_BITS  = ROW_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                page_ok,
  input  logic [COL_W-1:0]    col,
  input  logic                spare_off,
  input  logic [ROW_BITS-1:0] page_data,
  input  logic                pop,
  output logic                valid,
  output logic [7:0]          byte_out
);
  logic [ROW_BITS-1:0] sbuf_q;
  logic [COL_W-1:0]    ptr_q, left_q, pend_ptr_q, pend_len_q, stop;
  logic                pend_q;

  assign stop     = spare_off ? COL_W'(PAGE_BYTES) : COL_W'(ROW_BYTES);
  assign valid    = (left_q != '0);
  assign byte_out = 8'(sbuf_q >> {ptr_q, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      sbuf_q     <= '1;
      ptr_q      <= '0;
      left_q     <= '0;
      pend_q     <= 1'b0;
      pend_ptr_q <= '0;
      pend_len_q <= '0;
    end else begin
      if (valid && pop) begin
        ptr_q  <= ptr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (pend_q) begin
        sbuf_q <= page_data;
        ptr_q  <= pend_ptr_q;
        left_q <= pend_len_q;
        pend_q <= 1'b0;
      end
      if (start) begin
        left_q     <= '0;
        pend_q     <= 1'b1;
        pend_ptr_q <= col;
        pend_len_q <= (page_ok && (col < stop)) ? (stop - col) : '0;
      end
    end
  end
endmodule

// File: rtl/nand_pe_engine.sv
module nand_pe_engine
  import nand_pe_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES  = 48,
  parameter int BLK_PAGES  = 16,
  parameter int BUSY_CYC   = 20,
  localparam int SPARE_BYTES = PAGE_BYTES / 32,
  localparam int ROW_BYTES   = PAGE_BYTES + SPARE_BYTES,
  localparam int ROW_BITS    = ROW_BYTES * 8,
  localparam int COL_W       = $clog2(ROW_BYTES + 1),
  localparam int PG_W        = $clog2(NUM_PAGES),
  localparam int ROW_W       = PG_W + 1,
  localparam int CNT_MAX     = (BUSY_CYC > NUM_PAGES) ? BUSY_CYC : NUM_PAGES,
  localparam int CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start,
  input  logic [1:0]       op_kind,
  input  logic [ROW_W-1:0] op_row,
  input  logic [COL_W-1:0] op_col,
  input  logic             din_valid,
  input  logic [7:0]       din,
  input  logic             wp_n,
  input  logic             spare_off,
  input  logic             rd_pop,
  output logic             ready,
  output logic             dout_valid,
  output logic [7:0]       dout
);
  op_e             kind;
  logic            acc, acc_rd, acc_su, acc_cm, acc_er;
  logic            row_ok, blk_ok;
  logic [ROW_W-1:0] blk_base;
  logic            setup_q;
  logic [ROW_BITS-1:0] ibuf, mem_q, wdata;
  logic            pg_wr_q;
  logic [PG_W-1:0] pg_row_q, sw_page, waddr;
  logic            sw_act, we;
  logic [CNT_W-1:0] bcnt_q;

  assign kind     = op_e'(op_kind);
  assign acc      = op_start && ready;
  assign acc_rd   = acc && (kind == OP_READ);
  assign acc_su   = acc && (kind == OP_SETUP);
  assign acc_cm   = acc && (kind == OP_COMMIT);
  assign acc_er   = acc && (kind == OP_ERASE);
  assign row_ok   = op_row < ROW_W'(NUM_PAGES);
  assign blk_base = op_row & ~ROW_W'(BLK_PAGES - 1);
  assign blk_ok   = blk_base < ROW_W'(NUM_PAGES);

  always_ff @(posedge clk) begin
    if (rst)         setup_q <= 1'b0;
    else if (acc_su) setup_q <= 1'b1;
    else if (acc_cm) setup_q <= 1'b0;
  end

  nand_pe_inbuf #(.ROW_BYTES(ROW_BYTES), .COL_W(COL_W)) u_inbuf (
    .clk      (clk),
    .rst      (rst),
    .clear    (acc_su),
    .start_col(op_col),
    .wr       (din_valid && setup_q && !acc_su && !acc_cm),
    .wdat     (din),
    .bytes_q  (ibuf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_wr_q  <= 1'b0;
      pg_row_q <= '0;
    end else begin
      pg_wr_q <= acc_cm && row_ok && wp_n;
      if (acc_cm) pg_row_q <= op_row[PG_W-1:0];
    end
  end

  nand_pe_sweep #(.NUM_PAGES(NUM_PAGES), .BLK_PAGES(BLK_PAGES)) u_sweep (
    .clk  (clk),
    .rst  (rst),
    .start(acc_er && blk_ok && wp_n),
    .base (blk_base[PG_W-1:0]),
    .act  (sw_act),
    .page (sw_page)
  );

  assign we    = pg_wr_q || sw_act;
  assign waddr = pg_wr_q ? pg_row_q : sw_page;
  assign wdata = pg_wr_q ? (mem_q & ibuf) : '1;

  nand_pe_array #(.WIDTH(ROW_BITS), .DEPTH(NUM_PAGES)) u_array (
    .clk  (clk),
    .re   ((acc_rd || acc_cm) && row_ok),
    .raddr(op_row[PG_W-1:0]),
    .rdata(mem_q),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b0;
      bcnt_q <= CNT_W'(NUM_PAGES - 1);
    end else if (acc_cm || acc_er) begin
      ready  <= 1'b0;
      bcnt_q <= CNT_W'(BUSY_CYC - 1);
    end else if (!ready) begin
      if (bcnt_q == '0) ready  <= 1'b1;
      else              bcnt_q <= bcnt_q - 1'b1;
    end
  end

  nand_pe_rdstream #(.PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES), .COL_W(COL_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .start    (acc_rd),
    .page_ok  (row_ok),
    .col      (op_col),
    .spare_off(spare_off),
    .page_data(mem_q),
    .pop      (rd_pop),
    .valid    (dout_valid),
    .byte_out (dout)
  );
endmodule

// File: rtl/nand_pe_chk.sv
module nand_pe_chk #(
  parameter int BUSY_CYC = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       ready,
  input logic       dout_valid,
  input logic       rd_pop
);
  logic [15:0] busy_left;
  logic        rd_acc, wr_acc;

  assign rd_acc = op_start && ready && (op_kind == 2'd0);
  assign wr_acc = op_start && ready && (op_kind[1] == 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                  busy_left <= '0;
    else if (wr_acc)          busy_left <= 16'(BUSY_CYC);
    else if (busy_left != '0) busy_left <= busy_left - 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!ready && !dout_valid));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy_left != '0) |-> !ready);
  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (rst) (busy_left == 16'd1) |=> ready);
  // R11
  read_ready_chk: assert property (@(posedge clk) disable iff (rst) rd_acc |=> ready);
  // R2
  read_restart_chk: assert property (@(posedge clk) disable iff (rst) rd_acc |=> !dout_valid);
  // R2
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !rd_pop && !rd_acc) |=> dout_valid);
endmodule

bind nand_pe_engine nand_pe_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_start  (op_start),
  .op_kind   (op_kind),
  .ready     (ready),
  .dout_valid(dout_valid),
  .rd_pop    (rd_pop)
);

// File: tb/tb_nand_pe_engine.sv
module tb_nand_pe_engine;
  localparam int PAGE = 64, NUM = 48, BLK = 16, BUSY = 20;
  localparam int ROW = PAGE + PAGE / 32;

  logic clk = 1'b0, rst = 1'b1;
  logic op_start = 0, din_valid = 0, wp_n = 1, spare_off = 0, rd_pop = 0;
  logic [1:0] op_kind = 0;
  logic [6:0] op_row = 0, op_col = 0;
  logic [7:0] din = 0;
  logic ready, dout_valid;
  logic [7:0] dout;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  nand_pe_engine dut (.*);

  // behavioural reference
  logic [7:0] mm [NUM*ROW];
  logic [7:0] ib [ROW];
  logic [7:0] m_q[$], m_pq[$], got[$];
  bit m_ready, m_pend, m_setup;
  int m_bcnt, m_cnt, m_col;

  always @(posedge clk) begin
    bit rb;
    int stop, base;
    if (rst) begin
      m_ready = 0; m_bcnt = NUM - 1; m_pend = 0; m_setup = 0; m_cnt = 0; m_col = 0;
      m_q.delete(); m_pq.delete();
      for (int i = 0; i < NUM*ROW; i++) mm[i] = 8'hFF;
      for (int i = 0; i < ROW; i++) ib[i] = 8'hFF;
    end else begin
      rb = m_ready;
      if (m_q.size() > 0 && rd_pop) void'(m_q.pop_front());
      if (m_pend) begin m_q = m_pq; m_pend = 0; end
      if (!m_ready) begin
        if (m_bcnt == 0) m_ready = 1; else m_bcnt--;
      end
      if (op_start && rb) begin
        case (op_kind)
          2'd0: begin
            m_q.delete(); m_pq.delete();
            stop = spare_off ? PAGE : ROW;
            if (op_row < NUM) for (int c = op_col; c < stop; c++) m_pq.push_back(mm[op_row*ROW + c]);
            m_pend = 1;
          end
          2'd1: begin
            for (int i = 0; i < ROW; i++) ib[i] = 8'hFF;
            m_cnt = 0; m_col = op_col; m_setup = 1;
          end
          2'd2: begin
            m_setup = 0;
            if (op_row < NUM && wp_n) for (int c = 0; c < ROW; c++) mm[op_row*ROW + c] &= ib[c];
            m_ready = 0; m_bcnt = BUSY - 1;
          end
          default: begin
            base = op_row - (op_row % BLK);
            if (base < NUM && wp_n)
              for (int p = base; p < base + BLK; p++)
                for (int c = 0; c < ROW; c++) mm[p*ROW + c] = 8'hFF;
            m_ready = 0; m_bcnt = BUSY - 1;
          end
        endcase
      end
      if (din_valid && m_setup && !(op_start && rb && (op_kind == 2'd1 || op_kind == 2'd2))) begin
        if (m_cnt < ROW) begin
          if (m_col + m_cnt < ROW) ib[m_col + m_cnt] = din;
          m_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(ready == m_ready, cur_req, ready, m_ready, "ready vs model");
      chk(dout_valid == (m_q.size() != 0), cur_req, dout_valid, m_q.size() != 0, "dout_valid vs model");
      if (dout_valid && m_q.size() != 0) chk(dout == m_q[0], cur_req, dout, m_q[0], "dout vs model");
    end
  end

  function automatic logic [7:0] pv(int i); return 8'(i*37 + 11); endfunction
  function automatic logic [7:0] qv(int i); return 8'hF0 ^ 8'(i); endfunction

  task automatic do_op(input int kind, input int row, input int col);
    op_start = 1; op_kind = 2'(kind); op_row = 7'(row); op_col = 7'(col);
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic send(input logic [7:0] b);
    din_valid = 1; din = b;
    @(negedge clk);
    din_valid = 0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (!ready && cyc < 1000) begin @(negedge clk); cyc++; end
  endtask

  task automatic rd(input int row, input int col, input bit so);
    got.delete();
    spare_off = so;
    do_op(0, row, col);
    spare_off = 0;
    for (int i = 0; i < 100; i++) begin
      if (dout_valid) begin got.push_back(dout); rd_pop = 1; end
      else begin rd_pop = 0; if (got.size() > 0 || i > 4) break; end
      @(negedge clk);
    end
    rd_pop = 0;
  endtask

  initial begin
    int cyc;
    bit all_ff;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk(ready == 0, "R1", ready, 0, "ready low after reset");
    wait_ready(cyc);
    chk(cyc == NUM, "R1", cyc, NUM, "init sweep length");
    rd(0, 0, 0);
    all_ff = 1; foreach (got[i]) if (got[i] != 8'hFF) all_ff = 0;
    chk(got.size() == ROW && all_ff, "R1", got.size(), ROW, "erased page after reset");

    cur_req = "R4";
    do_op(1, 3, 0); for (int i = 0; i < ROW; i++) send(pv(i)); do_op(2, 3, 0);
    wait_ready(cyc);
    rd(3, 0, 0);
    chk(got.size() == ROW, "R2", got.size(), ROW, "full stream length");
    chk(got[65] == pv(65), "R4", got[65], pv(65), "first program spare byte");
    do_op(1, 3, 0); for (int i = 0; i < ROW; i++) send(qv(i)); do_op(2, 3, 0);
    wait_ready(cyc);
    rd(3, 0, 0);
    chk(got[7] == (pv(7) & qv(7)), "R4", got[7], pv(7) & qv(7), "AND of two programs");
    do_op(0, 3, 0);
    chk(ready == 1, "R11", ready, 1, "read keeps ready");
    repeat (3) @(negedge clk);
    rd_pop = 1; repeat (70) @(negedge clk); rd_pop = 0;

    cur_req = "R6";
    do_op(1, 5, 60); for (int i = 0; i < 10; i++) send(8'h30 + 8'(i)); do_op(2, 5, 0);
    wait_ready(cyc);
    rd(5, 58, 0);
    chk(got.size() == 8, "R2", got.size(), 8, "stream from column 58");
    chk(got[0] == 8'hFF && got[2] == 8'h30 && got[7] == 8'h35, "R6", got[7], 8'h35, "column placement");
    rd(5, 0, 0);
    chk(got[0] == 8'hFF && got[3] == 8'hFF, "R6", got[0], 8'hFF, "no wrap to low columns");
    do_op(1, 6, 0); for (int i = 0; i < 70; i++) send(8'(i) ^ 8'h5A); do_op(2, 6, 0);
    wait_ready(cyc);
    rd(6, 0, 0);
    chk(got[0] == 8'h5A && got[65] == (8'd65 ^ 8'h5A), "R6", got[0], 8'h5A, "overflow bytes dropped");

    cur_req = "R5";
    do_op(1, 7, 0); repeat (4) send(8'h00);
    do_op(1, 7, 0); send(8'hAA); do_op(2, 7, 0);
    wait_ready(cyc);
    rd(7, 0, 0);
    chk(got[0] == 8'hAA && got[1] == 8'hFF && got[3] == 8'hFF, "R5", got[1], 8'hFF, "setup clears buffer");

    cur_req = "R7";
    wp_n = 0;
    do_op(1, 8, 0); repeat (4) send(8'h00); do_op(2, 8, 0);
    wait_ready(cyc);
    do_op(3, 0, 0);
    wait_ready(cyc);
    wp_n = 1;
    rd(8, 0, 0);
    chk(got[0] == 8'hFF, "R7", got[0], 8'hFF, "protected program");
    rd(3, 0, 0);
    chk(got[0] == (pv(0) & qv(0)), "R7", got[0], pv(0) & qv(0), "protected erase");

    cur_req = "R8";
    do_op(1, 16, 64); send(8'h00); send(8'h00); do_op(2, 16, 0); wait_ready(cyc);
    do_op(1, 31, 0); send(8'h00); do_op(2, 31, 0); wait_ready(cyc);
    do_op(1, 32, 0); send(8'h00); do_op(2, 32, 0); wait_ready(cyc);
    do_op(3, 19, 0); wait_ready(cyc);
    rd(16, 64, 0);
    chk(got.size() == 2 && got[0] == 8'hFF && got[1] == 8'hFF, "R8", got[0], 8'hFF, "spare erased");
    rd(31, 0, 0);
    chk(got[0] == 8'hFF, "R8", got[0], 8'hFF, "last page of block erased");
    rd(32, 0, 0);
    chk(got[0] == 8'h00, "R8", got[0], 8'h00, "next block kept");

    cur_req = "R9";
    rd(50, 0, 0);
    chk(got.size() == 0, "R9", got.size(), 0, "out of range read");
    do_op(1, 74, 0); send(8'h00); do_op(2, 74, 0); wait_ready(cyc);
    do_op(3, 96, 0); wait_ready(cyc);
    rd(10, 0, 0);
    chk(got[0] == 8'hFF, "R9", got[0], 8'hFF, "no alias program");
    rd(32, 0, 0);
    chk(got[0] == 8'h00, "R9", got[0], 8'h00, "no alias erase");

    cur_req = "R3";
    rd(3, 0, 1);
    chk(got.size() == PAGE, "R3", got.size(), PAGE, "spare disabled length");
    rd(3, 64, 1);
    chk(got.size() == 0, "R3", got.size(), 0, "start past main end");
    rd(3, 65, 0);
    chk(got.size() == 1 && got[0] == (pv(65) & qv(65)), "R3", got[0], pv(65) & qv(65), "last spare byte");

    cur_req = "R10";
    do_op(1, 12, 0); send(8'h0F); do_op(2, 12, 0);
    do_op(0, 12, 0);
    do_op(3, 12, 0);
    wait_ready(cyc);
    chk(cyc + 2 == BUSY, "R10", cyc + 2, BUSY, "busy length with ignored ops");
    rd(12, 0, 0);
    chk(got[0] == 8'h0F && got[1] == 8'hFF, "R10", got[0], 8'h0F, "erase during busy ignored");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule